// File: doc/BRIEF.md
# Staggered Sample-Window Scheduler for Shared-Pad Converters

Several converters that take their input through one analogue pad can together deliver a multiple of a single converter's sample rate, provided their acquisition phases take turns. This scheduler accepts a runtime count of active converters and a single launch pulse. From these it drives, for each converter, a one-cycle start strobe and an acquisition-window enable. The start points are spread evenly across one conversion period, and no two acquisition windows are ever open in the same cycle. This avoids charge sharing on the common pad.

A conversion period lasts `PERIOD` cycles, and each acquisition window lasts `SAMPLE_LEN` cycles. With `n` converters enabled, converter `k` opens its window `k*floor(PERIOD/n)` cycles into each period. The period is counted from the cycle after the accepted launch. A count whose spacing is shorter than the acquisition window cannot be scheduled without overlap, so it is flagged and refused. A stop request lets the current period run to its end, after which the block returns to idle.

Top module: `adc_sample_scheduler`

## Requirements
- R1: A launch pulse seen while idle with a valid count starts the group. In the next cycle `busy_o` is 1, the period phase is 0, and bit 0 of `samp_strobe_o` is 1.
- R2: With `n` converters, bit k of `samp_strobe_o` (for k < n) is high for exactly one cycle, at phase `k*floor(PERIOD/n)`.
- R3: Bit k of `samp_en_o` (for k < n) is high during phases `k*floor(PERIOD/n)` through `k*floor(PERIOD/n)+SAMPLE_LEN-1`, and is low in every other phase.
- R4: The phase runs from 0 to `PERIOD-1` and wraps back to 0. Strobes and windows repeat identically in every period.
- R5: At most one bit of `samp_en_o` is high in any cycle.
- R6: Bits of `samp_strobe_o` and `samp_en_o` with index n or higher stay 0 for the whole run.
- R7: While idle, `config_error_o` is 1 exactly when the count is 0, the count is greater than `MAX_CONV`, or `floor(PERIOD/n) < SAMPLE_LEN`. A launch pulse given in that state is ignored: `busy_o` and every enable stay 0.
- R8: The count is captured only when a launch is accepted. Changes to `conv_count_i` while running have no effect on the schedule, and `config_error_o` stays 0 while running.
- R9: A launch pulse while running is ignored. The phase keeps counting without restarting.
- R10: A stop pulse takes effect at the end of the current period. The cycle at phase `PERIOD-1` still runs, and after it `busy_o` and all outputs are 0. This holds even when the stop arrives in that final cycle.
- R11: After reset, `busy_o`, `samp_strobe_o` and `samp_en_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch pulse for the whole group |
| stop_i | input | 1 | Request to halt at the end of the current period |
| conv_count_i | input | $clog2(MAX_CONV+1) | Number of converters to schedule |
| samp_strobe_o | output | MAX_CONV | One-cycle start-of-acquisition strobe per converter |
| samp_en_o | output | MAX_CONV | Acquisition-window enable per converter |
| busy_o | output | 1 | Group is running |
| config_error_o | output | 1 | Idle count cannot be scheduled without overlap |

## Verification
The bench builds the block with `MAX_CONV=8`, `PERIOD=80` and `SAMPLE_LEN=12`. These values keep counts 1 to 6 schedulable (spacing 80 down to 13). Counts 7 and 8 are rejected because of overlap, and 0 and 9..15 are rejected for range, so both kinds of refusal are reached within the port width. Counts 3 and 6 leave a remainder in the division, which exercises the floor in the spacing and the idle gap at the end of the period. Runs of two periods each cover the wrap, and runs with the stop placed both mid-period and in the last phase cover the end-of-period halt.

// File: rtl/adc_sched_pkg.sv
package adc_sched_pkg;

  // Cycles between consecutive converter starts for a given count.
  function automatic int slot_spacing(input int period, input int n);
    return (n <= 0) ? 0 : period / n;
  endfunction

  // True when the count can be scheduled without overlapping windows.
  function automatic bit count_schedulable(input int n, input int max_conv,
                                           input int period, input int len);
    if (n < 1 || n > max_conv) return 1'b0;
    return slot_spacing(period, n) >= len;
  endfunction

endpackage

// File: rtl/sched_phase_ctr.sv
module sched_phase_ctr #(
  parameter int PERIOD = 80,
  localparam int PH_W = $clog2(PERIOD)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            launch,
  input  logic            halt_req,
  output logic            running,
  output logic [PH_W-1:0] phase,
  output logic            period_end
);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(PERIOD - 1);

  logic halt_pend;

  assign period_end = running && (phase == LAST_PH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running   <= 1'b0;
      phase     <= '0;
      halt_pend <= 1'b0;
    end else if (launch) begin
      running   <= 1'b1;
      phase     <= '0;
      halt_pend <= 1'b0;
    end else if (running) begin
      if (period_end) begin
        phase <= '0;
        if (halt_pend || halt_req) begin
          running   <= 1'b0;
          halt_pend <= 1'b0;
        end
      end else begin
        phase <= phase + 1'b1;
        if (halt_req) halt_pend <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sched_cfg_latch.sv
module sched_cfg_latch
  import adc_sched_pkg::*;
#(
  parameter int MAX_CONV   = 16,
  parameter int PERIOD     = 80,
  parameter int SAMPLE_LEN = 26,
  localparam int CW   = $clog2(MAX_CONV + 1),
  localparam int PH_W = $clog2(PERIOD)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            capture,
  input  logic [CW-1:0]   count_in,
  output logic            count_bad,
  output logic [CW-1:0]   count_q,
  output logic [PH_W-1:0] spacing_q
);
  logic [PH_W-1:0] spacing_live;

  assign count_bad    = !count_schedulable(int'(count_in), MAX_CONV, PERIOD, SAMPLE_LEN);
  assign spacing_live = PH_W'(slot_spacing(PERIOD, int'(count_in)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q   <= '0;
      spacing_q <= '0;
    end else if (capture) begin
      count_q   <= count_in;
      spacing_q <= spacing_live;
    end
  end
endmodule

// File: rtl/sched_slot_decode.sv
module sched_slot_decode #(
  parameter int MAX_CONV   = 16,
  parameter int PERIOD     = 80,
  parameter int SAMPLE_LEN = 26,
  localparam int CW   = $clog2(MAX_CONV + 1),
  localparam int PH_W = $clog2(PERIOD),
  localparam int PW   = PH_W + CW + 1
) (
  input  logic                running,
  input  logic [PH_W-1:0]     phase,
  input  logic [CW-1:0]       count_q,
  input  logic [PH_W-1:0]     spacing_q,
  output logic [MAX_CONV-1:0] strobe,
  output logic [MAX_CONV-1:0] window
);
  logic [PW-1:0] phase_w;
  assign phase_w = PW'(phase);

  for (genvar k = 0; k < MAX_CONV; k++) begin : g_slot
    localparam logic [CW-1:0] KIDX = CW'(k);
    logic          in_use;
    logic [PW-1:0] open_at;
    logic [PW-1:0] close_at;

    assign in_use   = running && (KIDX < count_q);
    assign open_at  = PW'(spacing_q) * PW'(KIDX);
    assign close_at = open_at + PW'(SAMPLE_LEN);
    assign strobe[k] = in_use && (phase_w == open_at);
    assign window[k] = in_use && (phase_w >= open_at) && (phase_w < close_at);
  end
endmodule

// File: rtl/adc_sample_scheduler.sv
module adc_sample_scheduler #(
  parameter int MAX_CONV   = 16,
  parameter int PERIOD     = 80,
  parameter int SAMPLE_LEN = 26,
  localparam int CW   = $clog2(MAX_CONV + 1),
  localparam int PH_W = $clog2(PERIOD)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                stop_i,
  input  logic [CW-1:0]       conv_count_i,
  output logic [MAX_CONV-1:0] samp_strobe_o,
  output logic [MAX_CONV-1:0] samp_en_o,
  output logic                busy_o,
  output logic                config_error_o
);
  logic            running;
  logic [PH_W-1:0] phase;
  logic            period_end;
  logic            count_bad;
  logic [CW-1:0]   count_q;
  logic [PH_W-1:0] spacing_q;
  logic            launch;

  // Launch only from idle with a schedulable count.
  assign launch = start_i && !running && !count_bad;

  sched_phase_ctr #(.PERIOD(PERIOD)) u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch     (launch),
    .halt_req   (stop_i),
    .running    (running),
    .phase      (phase),
    .period_end (period_end)
  );

  sched_cfg_latch #(.MAX_CONV(MAX_CONV), .PERIOD(PERIOD), .SAMPLE_LEN(SAMPLE_LEN)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (launch),
    .count_in  (conv_count_i),
    .count_bad (count_bad),
    .count_q   (count_q),
    .spacing_q (spacing_q)
  );

  sched_slot_decode #(.MAX_CONV(MAX_CONV), .PERIOD(PERIOD), .SAMPLE_LEN(SAMPLE_LEN)) u_dec (
    .running   (running),
    .phase     (phase),
    .count_q   (count_q),
    .spacing_q (spacing_q),
    .strobe    (samp_strobe_o),
    .window    (samp_en_o)
  );

  assign busy_o         = running;
  assign config_error_o = !running && count_bad;
endmodule

// File: rtl/adc_sample_scheduler_chk.sv
module adc_sample_scheduler_chk #(
  parameter int MAX_CONV = 16,
  parameter int PERIOD   = 80,
  localparam int PH_W = $clog2(PERIOD)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start_i,
  input logic                launch,
  input logic                running,
  input logic [PH_W-1:0]     phase,
  input logic [MAX_CONV-1:0] samp_strobe_o,
  input logic [MAX_CONV-1:0] samp_en_o,
  input logic                config_error_o
);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(PERIOD - 1);

  a_r5_exclusive_windows: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(samp_en_o));

  a_r1_launch_phase_zero: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (running && phase == '0 && samp_strobe_o[0]));

  a_r4_phase_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (running && phase == LAST_PH) |=> (phase == '0));

  a_r2_strobe_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_strobe_o != '0) |=> ((samp_strobe_o & $past(samp_strobe_o)) == '0));

  a_r3_strobe_opens_window: assert property (@(posedge clk) disable iff (!rst_n)
    ((samp_strobe_o & ~samp_en_o) == '0));

  a_r7_error_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
    (config_error_o && start_i) |=> !running);

  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (running && start_i && phase != LAST_PH) |=> (phase == $past(phase) + 1'b1));
endmodule

bind adc_sample_scheduler adc_sample_scheduler_chk #(.MAX_CONV(MAX_CONV), .PERIOD(PERIOD)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .start_i        (start_i),
  .launch         (launch),
  .running        (running),
  .phase          (phase),
  .samp_strobe_o  (samp_strobe_o),
  .samp_en_o      (samp_en_o),
  .config_error_o (config_error_o)
);

// File: tb/adc_sample_scheduler_bench.sv
module adc_sample_scheduler_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MAXC = 8;
  localparam int PER  = 80;
  localparam int LEN  = 12;
  localparam int CW   = $clog2(MAXC + 1);

  // Stimulus table: count and whether it must be refused.
  localparam int NV = 10;
  localparam int TBL_N   [NV] = '{1, 2, 3, 4, 6, 0, 7, 8, 9, 15};
  localparam bit TBL_BAD [NV] = '{0, 0, 0, 0, 0, 1, 1, 1, 1, 1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic stop_i = 1'b0;
  logic [CW-1:0] conv_count_i = '0;
  logic [MAXC-1:0] samp_strobe_o, samp_en_o;
  logic busy_o, config_error_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_sample_scheduler #(.MAX_CONV(MAXC), .PERIOD(PER), .SAMPLE_LEN(LEN)) u_adc_sample_scheduler (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .conv_count_i(conv_count_i), .samp_strobe_o(samp_strobe_o),
    .samp_en_o(samp_en_o), .busy_o(busy_o), .config_error_o(config_error_o));

  task automatic check(string req, bit ok, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Compare every output against the bench's own schedule for phase ph.
  task automatic cmp_cycle(int n, int ph, bit second);
    logic [MAXC-1:0] es, ee;
    int sp;
    es = '0; ee = '0;
    sp = PER / n;
    for (int k = 0; k < MAXC; k++) begin
      if (k < n) begin
        es[k] = (ph == k * sp);
        ee[k] = (ph >= k * sp) && (ph < k * sp + LEN);
      end
    end
    check("R1", busy_o == 1'b1, "busy", busy_o, 1);
    check(second ? "R4" : "R2", samp_strobe_o == es, "strobe", samp_strobe_o, es);
    check("R3", samp_en_o == ee, "window", samp_en_o, ee);
    check("R6", ((samp_en_o | samp_strobe_o) >> n) == '0, "unused bits",
          (samp_en_o | samp_strobe_o) >> n, 0);
    check("R5", $countones(samp_en_o) <= 1, "window count", $countones(samp_en_o), 1);
  endtask

  task automatic check_idle(string req);
    check(req, busy_o == 1'b0, "busy", busy_o, 0);
    check(req, samp_en_o == '0, "window", samp_en_o, 0);
    check(req, samp_strobe_o == '0, "strobe", samp_strobe_o, 0);
  endtask

  // Launch with count n, run the given periods, stop in cycle stop_c.
  // At cycle poke_c, a launch pulse and a bad count are also applied.
  task automatic run_valid(int n, int periods, int stop_c, int poke_c);
    conv_count_i = CW'(n);
    #1;
    check("R7", config_error_o == 1'b0, "config_error for good count", config_error_o, 0);
    start_i = 1'b1;
    tick();
    start_i = 1'b0;
    for (int c = 0; c < periods * PER; c++) begin
      cmp_cycle(n, c % PER, c >= PER);
      if (c > poke_c && c < poke_c + 4)
        check("R8", config_error_o == 1'b0, "config_error while running", config_error_o, 0);
      if (c == stop_c) stop_i = 1'b1;
      if (c == poke_c) begin
        start_i = 1'b1;
        conv_count_i = CW'(7);
      end
      tick();
      stop_i = 1'b0;
      start_i = 1'b0;
    end
    check_idle("R10");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3);
    #1;
    check_idle("R11");
    rst_n = 1'b1;
    tick();
    check_idle("R11");

    // Table walk.
    for (int i = 0; i < NV; i++) begin
      if (TBL_BAD[i]) begin
        conv_count_i = CW'(TBL_N[i]);
        #1;
        check("R7", config_error_o == 1'b1, "config_error", config_error_o, 1);
        start_i = 1'b1;
        tick();
        start_i = 1'b0;
        tick();
        check_idle("R7");
      end else begin
        run_valid(TBL_N[i], 2, PER + 10, 1 << 20);
        tick();
      end
    end

    // R8/R9: mid-run launch and bad count are ignored.
    run_valid(4, 2, PER + 20, 30);
    conv_count_i = CW'(7);
    #1;
    check("R7", config_error_o == 1'b1, "config_error after run with bad count", config_error_o, 1);
    tick();

    // R10: stop arriving in the final phase still ends that period.
    run_valid(5, 1, PER - 1, 1 << 20);
    tick();
    check_idle("R10");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule